// File: doc/BRIEF.md
# Parallel Flash Pin Front End

This block sits between the package pins of a parallel NOR-style flash device and its internal logic. It decodes the active-low select, output-enable and write-enable pins, the sleep (power-down) pin and its high-voltage unlock level, the boot unlock pin and the word/byte width pin. From these it produces the internal read address, the tri-state enables for the low and high data byte lanes, and the data driven onto the output lanes. The data comes either from the array or from the status register.

Each write cycle is caught at its first sampled low write-enable. It then goes to one of three places: the command logic, the array as a program, or the erase engine. Which one depends on the arm inputs that the command decoder drives. A program or erase aimed at the boot region is dropped unless the region is unlocked, and the drop is recorded in the status register. While the sleep pin is low the block ignores every other input, floats all lanes and returns its state to array-read with a clear status register.

The array, the command decoder and the program/erase engine are outside this block. They connect through plain internal ports. The supply sensing for the programming voltage arrives as a level flag.

Top module: `flash_bus_fe`

## Requirements
- R1: With `bus_sel_n` high, both lane enables are low, `standby` is high, and no write strobe is produced.
- R2: `dq_oe_lo` is high in the same cycle exactly when `sleep_n`=1, `bus_sel_n`=0, `bus_oe_n`=0 and `bus_wr_n`=1. Otherwise all lanes float.
- R3: In word mode (`wide_mode`=1), `dq_oe_hi` follows `dq_oe_lo`, `rd_addr` equals `addr_in`, and `dq_out` carries the full `rd_data` word while the array view is selected.
- R4: In byte mode (`wide_mode`=0), `dq_oe_hi` stays low and `dq_out` = {8'h00, selected byte}. The selected byte is `rd_data[7:0]` when `dq_in[15]`=0 and `rd_data[15:8]` when `dq_in[15]`=1.
- R5: A write begins at the first rising clock edge that samples `bus_sel_n`=0 and `bus_wr_n`=0. With neither arm input set, `cmd_wr` pulses for exactly one cycle after that edge, with `cmd_data`=`dq_in[7:0]`.
- R6: With `arm_prog`=1, a write produces a one-cycle `arr_wr` with `wr_addr`=`addr_in`. In word mode `wr_data`=`dq_in` and `wr_mask`=2'b11. In byte mode `wr_data`={2{`dq_in[7:0]`}} and `wr_mask` is 2'b10 when `dq_in[15]`=1 and 2'b01 when it is 0. `arm_prog` wins over `arm_erase`.
- R7: With only `arm_erase`=1, a write produces a one-cycle `ers_go` with `wr_addr`=`addr_in`.
- R8: With default parameters the boot region is word addresses 0x7E000 to 0x7FFFF. A program or erase there issues no strobe unless `boot_unlock`=1 or `sleep_hv`=1. A dropped operation sets status bit 4.
- R9: Programs and erases outside the boot region (for example 0x7DFFF) are issued regardless of `boot_unlock`.
- R10: An issued program or erase clears status bit 7 (ready) until `op_end` pulses. If `vpp_ok` is sampled low while the operation runs, status bit 3 is set. `clr_req` clears bits 4 and 3.
- R11: After `view_stat_req`, `dq_out` = {8'h00, status}. After `view_arr_req`, `dq_out` carries array data again.
- R12: While `sleep_n`=0, both lane enables are low, `deep_pd`=1, `standby`=0 and write strobes stop. After release, the status register reads 8'h80 and the array view is selected.
- R13: If a write-enable low is held across the release of `sleep_n`, it starts no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_n | input | 1 | Device select, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_wr_n | input | 1 | Write enable, active low |
| sleep_n | input | 1 | Reset/power-down pin, active low |
| sleep_hv | input | 1 | Flag: sleep pin at elevated unlock level |
| boot_unlock | input | 1 | Boot region unlock pin (high unlocks) |
| wide_mode | input | 1 | 1 = 16-bit word mode, 0 = byte mode |
| addr_in | input | ADDR_W | Word address pins |
| dq_in | input | DQ_W | Data lanes as seen at the pins |
| dq_out | output | DQ_W | Data presented to the output lanes |
| dq_oe_lo | output | 1 | Drive enable for lanes 7..0 |
| dq_oe_hi | output | 1 | Drive enable for lanes 15..8 |
| standby | output | 1 | Deselected, low-power indication |
| deep_pd | output | 1 | Deep power-down indication |
| rd_addr | output | ADDR_W | Array read word address |
| rd_data | input | DQ_W | Array read word |
| arm_prog | input | 1 | Command logic: next write is a program |
| arm_erase | input | 1 | Command logic: next write is an erase confirm |
| view_stat_req | input | 1 | Pulse: show status on reads |
| view_arr_req | input | 1 | Pulse: show array on reads |
| clr_req | input | 1 | Pulse: clear status error bits |
| op_end | input | 1 | Pulse: engine finished the operation |
| vpp_ok | input | 1 | Programming voltage valid flag |
| cmd_wr | output | 1 | One-cycle write strobe to command logic |
| cmd_data | output | 8 | Command byte |
| arr_wr | output | 1 | One-cycle program strobe to the array |
| ers_go | output | 1 | One-cycle erase start strobe |
| wr_addr | output | ADDR_W | Target word address of program or erase |
| wr_data | output | DQ_W | Program data |
| wr_mask | output | 2 | Byte-lane mask of the program |

## Verification
The bench uses the default values: a 19-bit word address, 16 data lanes, and an 8192-word boot region at the top of the space. With these values the edge 0x7DFFF/0x7E000 can be reached directly, and so can both byte lanes through the top data pin. The tests cover both unlock paths into the boot region, status reads in the middle of an operation and after a programming-voltage drop, and a write-enable held low across a sleep release.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

    typedef enum logic {
        VIEW_ARRAY  = 1'b0,
        VIEW_STATUS = 1'b1
    } view_e;

    localparam int STAT_W   = 8;
    localparam int ST_READY = 7;
    localparam int ST_LOCK  = 4;
    localparam int ST_VPP   = 3;

endpackage

// File: rtl/fe_addr_dec.sv
module fe_addr_dec #(
    parameter int ADDR_W      = 19,
    parameter int BOOT_WORDS  = 8192,
    parameter bit BOOT_AT_TOP = 1'b1
) (
    input  logic              wide_mode,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic              dq_top,
    output logic              lane_hi,
    output logic              boot_hit
);

    // Byte lane choice: only meaningful in byte mode.
    assign lane_hi = ~wide_mode & dq_top;

    generate
        if (BOOT_AT_TOP) begin : g_top
            localparam logic [ADDR_W:0] LIM =
                (ADDR_W+1)'((64'd1 << ADDR_W) - 64'(BOOT_WORDS));
            assign boot_hit = ({1'b0, word_addr} >= LIM);
        end else begin : g_bot
            localparam logic [ADDR_W:0] LIM = (ADDR_W+1)'(BOOT_WORDS);
            assign boot_hit = ({1'b0, word_addr} < LIM);
        end
    endgenerate

endmodule

// File: rtl/fe_wr_route.sv
module fe_wr_route #(
    parameter int ADDR_W = 19,
    parameter int DQ_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_act,
    input  logic              sel,
    input  logic              we_low,
    input  logic              arm_prog,
    input  logic              arm_erase,
    input  logic              boot_hit,
    input  logic              boot_open,
    input  logic              wide_mode,
    input  logic              lane_hi,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [DQ_W-1:0]   dq,
    output logic              cmd_wr,
    output logic [7:0]        cmd_data,
    output logic              arr_wr,
    output logic              ers_go,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DQ_W-1:0]   wr_data,
    output logic [1:0]        wr_mask,
    output logic              lock_hit
);

    localparam int HALF = DQ_W / 2;

    typedef struct packed {
        logic              live;
        logic              we_low;
        logic              cmd_wr;
        logic [7:0]        cmd_data;
        logic              arr_wr;
        logic              ers_go;
        logic [ADDR_W-1:0] addr;
        logic [DQ_W-1:0]   data;
        logic [1:0]        mask;
        logic              lock_hit;
    } rt_t;

    rt_t q, d;
    logic start;

    always_comb begin
        d          = q;
        d.cmd_wr   = 1'b0;
        d.arr_wr   = 1'b0;
        d.ers_go   = 1'b0;
        d.lock_hit = 1'b0;
        d.live     = ~sleep_act;
        d.we_low   = ~sleep_act & sel & we_low;
        start      = ~sleep_act & q.live & sel & we_low & ~q.we_low;
        if (start) begin
            if (arm_prog || arm_erase) begin
                if (boot_hit && !boot_open) begin
                    d.lock_hit = 1'b1;
                end else if (arm_prog) begin
                    d.arr_wr = 1'b1;
                    d.addr   = word_addr;
                    if (wide_mode) begin
                        d.data = dq;
                        d.mask = 2'b11;
                    end else begin
                        d.data = {2{dq[HALF-1:0]}};
                        d.mask = lane_hi ? 2'b10 : 2'b01;
                    end
                end else begin
                    d.ers_go = 1'b1;
                    d.addr   = word_addr;
                end
            end else begin
                d.cmd_wr   = 1'b1;
                d.cmd_data = dq[7:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmd_wr   = q.cmd_wr;
    assign cmd_data = q.cmd_data;
    assign arr_wr   = q.arr_wr;
    assign ers_go   = q.ers_go;
    assign wr_addr  = q.addr;
    assign wr_data  = q.data;
    assign wr_mask  = q.mask;
    assign lock_hit = q.lock_hit;

endmodule

// File: rtl/fe_status.sv
module fe_status
    import flash_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_act,
    input  logic              lock_hit,
    input  logic              op_start,
    input  logic              op_end,
    input  logic              vpp_ok,
    input  logic              clr_req,
    input  logic              view_stat_req,
    input  logic              view_arr_req,
    output logic [STAT_W-1:0] stat,
    output view_e             view
);

    typedef struct packed {
        logic  lock_err;
        logic  vpp_err;
        logic  run;
        view_e view;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (op_start)    d.run = 1'b1;
        else if (op_end) d.run = 1'b0;
        if (lock_hit)          d.lock_err = 1'b1;
        if (q.run && !vpp_ok)  d.vpp_err  = 1'b1;
        if (clr_req) begin
            d.lock_err = 1'b0;
            d.vpp_err  = 1'b0;
        end
        if (view_stat_req)     d.view = VIEW_STATUS;
        else if (view_arr_req) d.view = VIEW_ARRAY;
        if (sleep_act) begin
            d.lock_err = 1'b0;
            d.vpp_err  = 1'b0;
            d.run      = 1'b0;
            d.view     = VIEW_ARRAY;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        stat           = '0;
        stat[ST_READY] = ~q.run;
        stat[ST_LOCK]  = q.lock_err;
        stat[ST_VPP]   = q.vpp_err;
    end

    assign view = q.view;

endmodule

// File: rtl/flash_bus_fe.sv
module flash_bus_fe
    import flash_fe_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int DQ_W        = 16,
    parameter int BOOT_WORDS  = 8192,
    parameter bit BOOT_AT_TOP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_n,
    input  logic              bus_oe_n,
    input  logic              bus_wr_n,
    input  logic              sleep_n,
    input  logic              sleep_hv,
    input  logic              boot_unlock,
    input  logic              wide_mode,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe_lo,
    output logic              dq_oe_hi,
    output logic              standby,
    output logic              deep_pd,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DQ_W-1:0]   rd_data,
    input  logic              arm_prog,
    input  logic              arm_erase,
    input  logic              view_stat_req,
    input  logic              view_arr_req,
    input  logic              clr_req,
    input  logic              op_end,
    input  logic              vpp_ok,
    output logic              cmd_wr,
    output logic [7:0]        cmd_data,
    output logic              arr_wr,
    output logic              ers_go,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DQ_W-1:0]   wr_data,
    output logic [1:0]        wr_mask
);

    localparam int HALF = DQ_W / 2;

    logic              sleep_act, active, lane_hi, boot_hit, lock_hit;
    logic [STAT_W-1:0] stat_w;
    view_e             view_w;
    logic              view_is_stat;

    assign sleep_act    = ~sleep_n;
    assign active       = sleep_n & ~bus_sel_n;
    assign dq_oe_lo     = active & ~bus_oe_n & bus_wr_n;
    assign dq_oe_hi     = dq_oe_lo & wide_mode;
    assign standby      = sleep_n & bus_sel_n;
    assign deep_pd      = sleep_act;
    assign rd_addr      = addr_in;
    assign view_is_stat = (view_w == VIEW_STATUS);

    fe_addr_dec #(
        .ADDR_W(ADDR_W), .BOOT_WORDS(BOOT_WORDS), .BOOT_AT_TOP(BOOT_AT_TOP)
    ) u_dec (
        .wide_mode (wide_mode),
        .word_addr (addr_in),
        .dq_top    (dq_in[DQ_W-1]),
        .lane_hi   (lane_hi),
        .boot_hit  (boot_hit)
    );

    fe_wr_route #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_act (sleep_act),
        .sel       (~bus_sel_n),
        .we_low    (~bus_wr_n),
        .arm_prog  (arm_prog),
        .arm_erase (arm_erase),
        .boot_hit  (boot_hit),
        .boot_open (boot_unlock | sleep_hv),
        .wide_mode (wide_mode),
        .lane_hi   (lane_hi),
        .word_addr (addr_in),
        .dq        (dq_in),
        .cmd_wr    (cmd_wr),
        .cmd_data  (cmd_data),
        .arr_wr    (arr_wr),
        .ers_go    (ers_go),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_mask   (wr_mask),
        .lock_hit  (lock_hit)
    );

    fe_status u_stat (
        .clk           (clk),
        .rst_n         (rst_n),
        .sleep_act     (sleep_act),
        .lock_hit      (lock_hit),
        .op_start      (arr_wr | ers_go),
        .op_end        (op_end),
        .vpp_ok        (vpp_ok),
        .clr_req       (clr_req),
        .view_stat_req (view_stat_req),
        .view_arr_req  (view_arr_req),
        .stat          (stat_w),
        .view          (view_w)
    );

    always_comb begin
        if (view_is_stat) begin
            dq_out = DQ_W'(stat_w);
        end else if (wide_mode) begin
            dq_out = rd_data;
        end else begin
            dq_out = {{HALF{1'b0}}, (lane_hi ? rd_data[DQ_W-1:HALF] : rd_data[HALF-1:0])};
        end
    end

endmodule

// File: rtl/flash_bus_fe_chk.sv
module flash_bus_fe_chk
    import flash_fe_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int BOOT_WORDS  = 8192,
    parameter bit BOOT_AT_TOP = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_n,
    input logic              sleep_hv,
    input logic              boot_unlock,
    input logic              wide_mode,
    input logic              bus_sel_n,
    input logic              bus_oe_n,
    input logic              dq_oe_lo,
    input logic              dq_oe_hi,
    input logic              cmd_wr,
    input logic              arr_wr,
    input logic              ers_go,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [STAT_W-1:0] stat,
    input logic              view_stat
);

    localparam logic [ADDR_W:0] LO_LIM =
        (ADDR_W+1)'((64'd1 << ADDR_W) - 64'(BOOT_WORDS));
    localparam logic [ADDR_W:0] HI_LIM = (ADDR_W+1)'(BOOT_WORDS);

    logic in_boot;
    assign in_boot = BOOT_AT_TOP ? ({1'b0, wr_addr} >= LO_LIM)
                                 : ({1'b0, wr_addr} <  HI_LIM);

    // R2
    lane_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_lo |-> (!bus_sel_n && !bus_oe_n && sleep_n));

    // R4
    byte_hi_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode |-> !dq_oe_hi);

    // R5
    one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_wr, arr_wr, ers_go}));

    // R5
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> !cmd_wr);

    // R8
    boot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((arr_wr || ers_go) && in_boot) |-> $past(boot_unlock || sleep_hv));

    // R12
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_n && $past(!sleep_n)) |-> !(cmd_wr || arr_wr || ers_go));

    // R12
    sleep_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n |-> (!dq_oe_lo && !dq_oe_hi));

    // R12
    sleep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n |=> (!stat[ST_LOCK] && !stat[ST_VPP] && !view_stat));

endmodule

bind flash_bus_fe flash_bus_fe_chk #(
    .ADDR_W(ADDR_W), .BOOT_WORDS(BOOT_WORDS), .BOOT_AT_TOP(BOOT_AT_TOP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_n     (sleep_n),
    .sleep_hv    (sleep_hv),
    .boot_unlock (boot_unlock),
    .wide_mode   (wide_mode),
    .bus_sel_n   (bus_sel_n),
    .bus_oe_n    (bus_oe_n),
    .dq_oe_lo    (dq_oe_lo),
    .dq_oe_hi    (dq_oe_hi),
    .cmd_wr      (cmd_wr),
    .arr_wr      (arr_wr),
    .ers_go      (ers_go),
    .wr_addr     (wr_addr),
    .stat        (stat_w),
    .view_stat   (view_is_stat)
);

// File: tb/flash_bus_fe_tb.sv
module flash_bus_fe_tb;

    localparam int AW = 19;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel_n = 1'b1, bus_oe_n = 1'b1, bus_wr_n = 1'b1;
    logic          sleep_n = 1'b1, sleep_hv = 1'b0, boot_unlock = 1'b0;
    logic          wide_mode = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe_lo, dq_oe_hi, standby, deep_pd;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          arm_prog = 1'b0, arm_erase = 1'b0;
    logic          view_stat_req = 1'b0, view_arr_req = 1'b0, clr_req = 1'b0;
    logic          op_end = 1'b0, vpp_ok = 1'b1;
    logic          cmd_wr, arr_wr, ers_go;
    logic [7:0]    cmd_data;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [1:0]    wr_mask;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] mdl(logic [AW-1:0] a);
        return 16'hA55A ^ a[15:0];
    endfunction

    assign rd_data = mdl(rd_addr);

    flash_bus_fe u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_oe_n(bus_oe_n),
        .bus_wr_n(bus_wr_n), .sleep_n(sleep_n), .sleep_hv(sleep_hv),
        .boot_unlock(boot_unlock), .wide_mode(wide_mode), .addr_in(addr_in),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi),
        .standby(standby), .deep_pd(deep_pd), .rd_addr(rd_addr), .rd_data(rd_data),
        .arm_prog(arm_prog), .arm_erase(arm_erase), .view_stat_req(view_stat_req),
        .view_arr_req(view_arr_req), .clr_req(clr_req), .op_end(op_end),
        .vpp_ok(vpp_ok), .cmd_wr(cmd_wr), .cmd_data(cmd_data), .arr_wr(arr_wr),
        .ers_go(ers_go), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask)
    );

    // Scoreboard item: route 1 = command, 2 = program, 3 = erase
    typedef struct {
        int            route;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [1:0]    mask;
        string         req;
    } item_t;

    item_t sb[$];

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(int rt, logic [AW-1:0] a, logic [DW-1:0] dt,
                        logic [1:0] m, string req);
        item_t it;
        it.route = rt; it.addr = a; it.data = dt; it.mask = m; it.req = req;
        sb.push_back(it);
    endtask

    // Monitor: every strobe must match the head of the queue
    always @(negedge clk) begin
        if (rst_n && (cmd_wr || arr_wr || ers_go)) begin
            int rt;
            rt = cmd_wr ? 1 : (arr_wr ? 2 : 3);
            if (sb.size() == 0) begin
                check(1'b0, "R8/R12/R13 unexpected strobe", 32'(rt), 32'd0);
            end else begin
                item_t e;
                e = sb.pop_front();
                check(rt == e.route, e.req, 32'(rt), 32'(e.route));
                if (rt == 1) begin
                    check(cmd_data == e.data[7:0], e.req, 32'(cmd_data), 32'(e.data[7:0]));
                end else begin
                    check(wr_addr == e.addr, e.req, 32'(wr_addr), 32'(e.addr));
                    if (rt == 2) begin
                        check(wr_data == e.data, e.req, 32'(wr_data), 32'(e.data));
                        check(wr_mask == e.mask, e.req, 32'(wr_mask), 32'(e.mask));
                    end
                end
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] dt);
        addr_in = a; dq_in = dt; bus_sel_n = 1'b0; bus_wr_n = 1'b0;
        cyc(2);
        bus_wr_n = 1'b1; bus_sel_n = 1'b1;
        cyc(1);
    endtask

    task automatic pulse_op_end();
        op_end = 1'b1; cyc(1); op_end = 1'b0;
    endtask

    task automatic show_status();
        view_stat_req = 1'b1; cyc(1); view_stat_req = 1'b0;
    endtask

    task automatic show_array();
        view_arr_req = 1'b1; cyc(1); view_arr_req = 1'b0;
    endtask

    task automatic clear_status();
        clr_req = 1'b1; cyc(1); clr_req = 1'b0;
    endtask

    // Status is read on the low lanes, word mode, device selected
    task automatic read_status(logic [7:0] exp, string req);
        wide_mode = 1'b1; bus_sel_n = 1'b0; bus_oe_n = 1'b0; #1;
        check(dq_out == {8'h00, exp}, req, 32'(dq_out), 32'({8'h00, exp}));
        bus_sel_n = 1'b1; bus_oe_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset / deselected state
        check(!dq_oe_lo && !dq_oe_hi, "R1 lanes idle", {dq_oe_hi, dq_oe_lo}, 0);
        check(standby == 1'b1, "R1 standby", standby, 1);
        check(deep_pd == 1'b0, "R12 no deep_pd", deep_pd, 0);

        // R3 word read
        addr_in = 19'h12345; bus_sel_n = 1'b0; bus_oe_n = 1'b0; #1;
        check(dq_oe_lo && dq_oe_hi, "R3 both lanes", {dq_oe_hi, dq_oe_lo}, 3);
        check(dq_out == mdl(19'h12345), "R3 word data", dq_out, mdl(19'h12345));
        check(rd_addr == 19'h12345, "R3 read address", rd_addr, 19'h12345);
        // R2 output enable high floats lanes
        bus_oe_n = 1'b1; #1;
        check(!dq_oe_lo, "R2 oe high", dq_oe_lo, 0);
        bus_oe_n = 1'b0; bus_wr_n = 1'b0; #1;
        check(!dq_oe_lo, "R2 write low floats", dq_oe_lo, 0);
        bus_wr_n = 1'b1; bus_sel_n = 1'b1; #1;
        // R1 deselected with oe low
        check(!dq_oe_lo && standby, "R1 deselected", {standby, dq_oe_lo}, 2);
        bus_oe_n = 1'b1;

        // R4 byte reads
        wide_mode = 1'b0; bus_sel_n = 1'b0; bus_oe_n = 1'b0;
        addr_in = 19'h00ABC; dq_in = 16'h0000; #1;
        check(!dq_oe_hi && dq_oe_lo, "R4 hi lanes float", {dq_oe_hi, dq_oe_lo}, 1);
        check(dq_out == {8'h00, mdl(19'h00ABC)[7:0]}, "R4 low byte",
              dq_out, {8'h00, mdl(19'h00ABC)[7:0]});
        dq_in = 16'h8000; #1;
        check(dq_out == {8'h00, mdl(19'h00ABC)[15:8]}, "R4 high byte",
              dq_out, {8'h00, mdl(19'h00ABC)[15:8]});
        bus_sel_n = 1'b1; bus_oe_n = 1'b1; wide_mode = 1'b1; dq_in = '0;
        cyc(1);

        // R5 command write
        push(1, '0, 16'h1240, 2'b00, "R5 command route");
        do_write(19'h00010, 16'h1240);

        // R6 program, word and both byte lanes
        arm_prog = 1'b1;
        push(2, 19'h00100, 16'hBEEF, 2'b11, "R6 word program");
        do_write(19'h00100, 16'hBEEF);
        pulse_op_end();
        wide_mode = 1'b0;
        push(2, 19'h00101, 16'h3C3C, 2'b10, "R6 byte program hi");
        do_write(19'h00101, 16'h803C);
        pulse_op_end();
        push(2, 19'h00102, 16'h5A5A, 2'b01, "R6 byte program lo");
        do_write(19'h00102, 16'h005A);
        pulse_op_end();
        wide_mode = 1'b1;
        // R6 program wins over erase
        arm_erase = 1'b1;
        push(2, 19'h00103, 16'h1111, 2'b11, "R6 program priority");
        do_write(19'h00103, 16'h1111);
        pulse_op_end();
        arm_prog = 1'b0;

        // R7 erase
        push(3, 19'h04000, '0, 2'b00, "R7 erase route");
        do_write(19'h04000, 16'h00D0);
        pulse_op_end();

        // R9 just below boot region, locked
        push(3, 19'h7DFFF, '0, 2'b00, "R9 below boot erase");
        do_write(19'h7DFFF, 16'h00D0);
        pulse_op_end();

        // R8 boot erase blocked
        do_write(19'h7E000, 16'h00D0);
        show_status();
        read_status(8'h90, "R8 lock bit");
        clear_status();
        read_status(8'h80, "R10 clear");

        // R8 unlock by pin
        arm_erase = 1'b0; arm_prog = 1'b1; boot_unlock = 1'b1;
        push(2, 19'h7F000, 16'h2222, 2'b11, "R8 unlocked program");
        do_write(19'h7F000, 16'h2222);
        pulse_op_end();
        // R8 unlock by elevated sleep level
        boot_unlock = 1'b0; sleep_hv = 1'b1; arm_prog = 1'b0; arm_erase = 1'b1;
        push(3, 19'h7FFFF, '0, 2'b00, "R8 hv erase");
        do_write(19'h7FFFF, 16'h00D0);
        pulse_op_end();
        sleep_hv = 1'b0; arm_erase = 1'b0;
        read_status(8'h80, "R8 no lock bit");

        // R10 running, vpp drop, end
        arm_prog = 1'b1;
        push(2, 19'h00200, 16'h3333, 2'b11, "R10 program");
        do_write(19'h00200, 16'h3333);
        read_status(8'h00, "R10 busy");
        vpp_ok = 1'b0; cyc(1); vpp_ok = 1'b1;
        read_status(8'h08, "R10 vpp error");
        pulse_op_end();
        read_status(8'h88, "R10 ready with vpp error");
        clear_status();
        arm_prog = 1'b0;

        // R11 back to array view
        show_array();
        addr_in = 19'h00777; bus_sel_n = 1'b0; bus_oe_n = 1'b0; #1;
        check(dq_out == mdl(19'h00777), "R11 array view", dq_out, mdl(19'h00777));
        bus_sel_n = 1'b1; bus_oe_n = 1'b1;

        // R12 sleep: set lock bit and status view first
        arm_prog = 1'b1;
        do_write(19'h7E010, 16'h4444);
        arm_prog = 1'b0;
        show_status();
        sleep_n = 1'b0; bus_sel_n = 1'b0; bus_oe_n = 1'b0; #1;
        check(!dq_oe_lo && !dq_oe_hi, "R12 lanes float", {dq_oe_hi, dq_oe_lo}, 0);
        check(deep_pd && !standby, "R12 flags", {deep_pd, standby}, 2);
        bus_oe_n = 1'b1; bus_wr_n = 1'b0; cyc(2); bus_wr_n = 1'b1;
        cyc(1);
        sleep_n = 1'b1; bus_oe_n = 1'b0; addr_in = 19'h00321; #1;
        check(dq_out == mdl(19'h00321), "R12 array view after release",
              dq_out, mdl(19'h00321));
        bus_sel_n = 1'b1; bus_oe_n = 1'b1;
        cyc(1);
        show_status();
        read_status(8'h80, "R12 status cleared");
        show_array();

        // R13 write enable held across release
        sleep_n = 1'b0; bus_sel_n = 1'b0; bus_wr_n = 1'b0; dq_in = 16'h00AA;
        cyc(2);
        sleep_n = 1'b1;
        cyc(3);
        bus_wr_n = 1'b1; bus_sel_n = 1'b1;
        cyc(2);
        push(1, '0, 16'h0055, 2'b00, "R13 later write works");
        do_write(19'h00000, 16'h0055);
        cyc(2);

        check(sb.size() == 0, "R5 all expected strobes seen", sb.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule